// File: doc/BRIEF.md
# Serial Module Stop-Mode Clock Controller

This block sits in front of a dual-channel serial peripheral and decides whether its two reference clocks run. A host on the bus clock writes a control register that holds a stop flag. While the flag is set, the oscillator-derived reference clock and the serial clock handed to the peripheral are held low. The bus clock itself is never gated, so the control register can still be read and written. Every other register of the peripheral answers with a bus error while the block is stopped.

Each gated clock has its own enable. That enable is resynchronised in the clock's own domain and captured by a latch that is open only while the clock is low. A clock therefore starts and stops on a whole cycle and never emits a shortened high pulse.

The block also samples the clear-to-send inputs of both channels on the rising edge of one of the two gated clocks, chosen by a select flag in the control register. It exposes the oscillator-not-ready input in a read-only status register, so that software can poll for a stable oscillator after leaving stop.

Top module: `scg_stop_ctrl`

## Requirements
- R1: After reset the control register reads 0, no response is pending, and both gated clocks toggle.
- R2: When control bit 0 (stop) is 1, `gclk_ref` and `gclk_ser` stay low within a few cycles of their own source clocks and produce no rising edge.
- R3: Every high pulse on `gclk_ref` and `gclk_ser` lasts a full half period of its source clock, including around stop and restart.
- R4: The control register at address 0 is written and read back with `bus_ack` in both the running and the stopped state. Only bits 1:0 are kept and the other bits read 0.
- R5: While stopped, any access to an address other than 0 responds with `bus_err` high and `bus_ack` low.
- R6: While running, any access to an address other than 0 responds with `bus_ack` high and `bus_err` low.
- R7: Clearing the stop bit, or applying a hardware reset while stopped, restarts both gated clocks.
- R8: A read of the status register at address 1 returns in bit 0 the level of `osc_rdy_n`, resynchronised to the bus clock. A stable oscillator reads 0.
- R9: `cts_q` shows the inputs captured on `gclk_ser` when control bit 1 is 1, and those captured on `gclk_ref` when it is 0.
- R10: A channel whose `cts_en` bit is 0 holds its captured value; a channel whose bit is 1 follows `cts_in`.
- R11: Each request produces exactly one of `bus_ack` or `bus_err`, as a one-cycle pulse in the cycle after the request.
- R12: While stopped, `cts_q` holds its value whatever `cts_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, never gated |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_ref | input | 1 | Oscillator or external reference clock |
| clk_ser | input | 1 | Serial clock |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Register address within the peripheral |
| bus_wdata | input | DW | Write data |
| osc_rdy_n | input | 1 | Oscillator not ready (0 = stable) |
| cts_in | input | NCH | Clear-to-send inputs, one per channel |
| cts_en | input | NCH | Clear-to-send sampling enable, one per channel |
| bus_ack | output | 1 | Access completed normally |
| bus_err | output | 1 | Access ended with bus error |
| bus_rdata | output | DW | Read data, valid with `bus_ack` |
| gclk_ref | output | 1 | Gated reference clock |
| gclk_ser | output | 1 | Gated serial clock |
| cts_q | output | NCH | Captured clear-to-send levels |

## Verification
The bench uses the default parameters: an address width of 4, a data width of 8, two channels and two synchroniser stages. With a 16-entry address space the bench can sweep all fifteen non-control addresses in both the stopped and the running state. With two channels it can give them different enables and catch crossed capture bits. Two synchroniser stages keep the stop and restart latency short enough to measure every gated pulse across several transitions.

// File: rtl/scg_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the stop-mode clock controller.
// Assumes address and data widths are chosen by the top module.
package scg_pkg;
    localparam int CTRL_ADDR   = 0;  // control register
    localparam int STAT_ADDR   = 1;  // status register
    localparam int STOP_BIT    = 0;  // control: stop all gated clocks
    localparam int CAPSEL_BIT  = 1;  // control: 1 = serial clock captures clear-to-send
    localparam int OSC_BIT     = 0;  // status: oscillator not ready
    localparam int NUM_GCLK    = 2;  // gated clocks: 0 = reference, 1 = serial
endpackage

// File: rtl/scg_sync.sv
`timescale 1ns/1ps
// Module: scg_sync
// A multi-stage level synchroniser into the domain of clk.
// Assumes the input is a slowly changing level, and STAGES >= 2.
module scg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/scg_icg.sv
`timescale 1ns/1ps
// Module: scg_icg
// Latch-based clock gate model. The latch is transparent only while
// clk_in is low, so the enable can only change the output between pulses.
// Assumes en is launched from a flop clocked on the rising edge of clk_in.
module scg_icg (
    input  logic clk_in,
    input  logic en,
    output logic clk_out
);
    logic en_lat;

    // Hold the enable for the whole high phase.
    always_latch begin
        if (!clk_in) en_lat <= en;
    end

    assign clk_out = clk_in & en_lat;
endmodule

// File: rtl/scg_cts_cap.sv
`timescale 1ns/1ps
// Module: scg_cts_cap
// One bank of clear-to-send capture flops on a (gated) capture clock.
// Each channel samples its input only when its enable is set.
// Assumes cts_en is quasi-static with respect to clk.
module scg_cts_cap #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] cts_in,
    input  logic [NCH-1:0] cts_en,
    output logic [NCH-1:0] q
);
    // Sample each enabled channel on the rising capture edge.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (cts_in & cts_en) | (q & ~cts_en);
    end

    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_en == '0) |=> $stable(q)); // R10
endmodule

// File: rtl/scg_regs.sv
`timescale 1ns/1ps
// Module: scg_regs
// Bus-clock register file: control (stop, capture select) and status.
// Responds to every request one cycle later with ack or bus error.
// Non-control addresses fail with an error while stopped.
// Assumes at most one request per cycle and DW >= 2.
module scg_regs #(
    parameter int AW          = 4,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_req,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          osc_rdy_n,
    output logic          bus_ack,
    output logic          bus_err,
    output logic [DW-1:0] bus_rdata,
    output logic          stop_o,
    output logic          capsel_o
);
    import scg_pkg::*;

    localparam logic [DW-1:0] CTRL_MASK = DW'((1 << STOP_BIT) | (1 << CAPSEL_BIT));

    logic [DW-1:0] ctrl_q;
    logic          osc_s;
    logic          hit_ctrl;
    logic          hit_stat;
    logic [DW-1:0] stat_word;

    scg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_osc_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (osc_rdy_n),
        .q     (osc_s)
    );

    // Decode the two locally owned addresses.
    always_comb begin
        hit_ctrl  = (bus_addr == AW'(CTRL_ADDR));
        hit_stat  = (bus_addr == AW'(STAT_ADDR));
        stat_word = '0;
        stat_word[OSC_BIT] = osc_s;
    end

    // Register writes, read data and the one-cycle response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            bus_ack   <= 1'b0;
            bus_err   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ack   <= 1'b0;
            bus_err   <= 1'b0;
            bus_rdata <= '0;
            if (bus_req) begin
                if (hit_ctrl) begin
                    bus_ack <= 1'b1;
                    if (bus_wr) ctrl_q    <= bus_wdata & CTRL_MASK;
                    else        bus_rdata <= ctrl_q;
                end else if (ctrl_q[STOP_BIT]) begin
                    bus_err <= 1'b1;
                end else begin
                    bus_ack <= 1'b1;
                    if (!bus_wr && hit_stat) bus_rdata <= stat_word;
                end
            end
        end
    end

    assign stop_o   = ctrl_q[STOP_BIT];
    assign capsel_o = ctrl_q[CAPSEL_BIT];

    AST_ERR_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && stop_o && !hit_ctrl) |=> (bus_err && !bus_ack)); // R5
    AST_ACK_WHEN_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !stop_o) |=> (bus_ack && !bus_err)); // R6
    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> $countones({bus_ack, bus_err}) == 1); // R11
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |=> !(bus_ack || bus_err)); // R11
endmodule

// File: rtl/scg_stop_ctrl.sv
`timescale 1ns/1ps
// Module: scg_stop_ctrl (top)
// Stop-mode controller for a dual-channel serial peripheral. It gates the
// reference and serial clocks glitch-free, keeps the control register
// alive on the bus clock and selects the clear-to-send capture clock.
// Assumes rst_n is held for several cycles of every source clock.
module scg_stop_ctrl #(
    parameter int AW          = 4,
    parameter int DW          = 8,
    parameter int NCH         = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clk_ref,
    input  logic           clk_ser,
    input  logic           bus_req,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    input  logic           osc_rdy_n,
    input  logic [NCH-1:0] cts_in,
    input  logic [NCH-1:0] cts_en,
    output logic           bus_ack,
    output logic           bus_err,
    output logic [DW-1:0]  bus_rdata,
    output logic           gclk_ref,
    output logic           gclk_ser,
    output logic [NCH-1:0] cts_q
);
    import scg_pkg::*;

    logic                          stop;
    logic                          capsel;
    logic [NUM_GCLK-1:0]           src_clk;
    logic [NUM_GCLK-1:0]           en_s;
    logic [NUM_GCLK-1:0]           gclk;
    logic [NUM_GCLK-1:0][NCH-1:0]  cap_q;

    scg_regs #(.AW(AW), .DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .osc_rdy_n (osc_rdy_n),
        .bus_ack   (bus_ack),
        .bus_err   (bus_err),
        .bus_rdata (bus_rdata),
        .stop_o    (stop),
        .capsel_o  (capsel)
    );

    assign src_clk = {clk_ser, clk_ref};

    // One enable synchroniser, clock gate and capture bank per gated clock.
    for (genvar g = 0; g < NUM_GCLK; g++) begin : g_dom
        scg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_en_sync (
            .clk   (src_clk[g]),
            .rst_n (rst_n),
            .d     (~stop),
            .q     (en_s[g])
        );

        scg_icg u_icg (
            .clk_in  (src_clk[g]),
            .en      (en_s[g]),
            .clk_out (gclk[g])
        );

        scg_cts_cap #(.NCH(NCH)) u_cap (
            .clk    (gclk[g]),
            .rst_n  (rst_n),
            .cts_in (cts_in),
            .cts_en (cts_en),
            .q      (cap_q[g])
        );

        AST_GATE_OFF_WHEN_DISABLED: assert property (@(posedge src_clk[g]) disable iff (!rst_n)
            (!en_s[g] && !$past(en_s[g])) |-> !gclk[g]); // R2
    end

    // Pick the bank captured by the selected clock.
    always_comb begin
        cts_q = capsel ? cap_q[1] : cap_q[0];
    end

    assign gclk_ref = gclk[0];
    assign gclk_ser = gclk[1];
endmodule

// File: tb/scg_stop_ctrl_tb.sv
`timescale 1ns/1ps
module scg_stop_ctrl_tb;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int NCH = 2;

    logic clk = 0, rst_n = 0, clk_ref = 0, clk_ser = 0, ser_run = 1;
    logic bus_req = 0, bus_wr = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic osc_rdy_n = 1;
    logic [NCH-1:0] cts_in = '0, cts_en = '1;
    logic bus_ack, bus_err, gclk_ref, gclk_ser;
    logic [DW-1:0] bus_rdata;
    logic [NCH-1:0] cts_q;

    int checks = 0, errors = 0;
    int n_ref = 0, n_ser = 0, short_ref = 0, short_ser = 0;
    logic mon_on = 0;
    realtime t_ref = 0, t_ser = 0;

    always #2 clk = ~clk;
    always #5 clk_ref = ~clk_ref;
    always #7 clk_ser = ser_run ? ~clk_ser : 1'b0;

    scg_stop_ctrl #(.AW(AW), .DW(DW), .NCH(NCH), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_ref(clk_ref), .clk_ser(clk_ser),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .osc_rdy_n(osc_rdy_n), .cts_in(cts_in),
        .cts_en(cts_en), .bus_ack(bus_ack), .bus_err(bus_err),
        .bus_rdata(bus_rdata), .gclk_ref(gclk_ref), .gclk_ser(gclk_ser),
        .cts_q(cts_q)
    );

    // Pulse counters and width monitors (R3)
    always @(posedge gclk_ref) begin n_ref++; t_ref = $realtime; end
    always @(posedge gclk_ser) begin n_ser++; t_ser = $realtime; end
    always @(negedge gclk_ref) if (mon_on && ($realtime - t_ref) < 4.99) short_ref++;
    always @(negedge gclk_ser) if (mon_on && ($realtime - t_ser) < 6.99) short_ser++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic xfer(input int addr, input logic wr, input int wd,
                        output logic ack, output logic err, output int rd);
        @(negedge clk);
        bus_req = 1; bus_wr = wr; bus_addr = AW'(addr); bus_wdata = DW'(wd);
        @(negedge clk);
        bus_req = 0; bus_wr = 0;
        ack = bus_ack; err = bus_err; rd = int'(bus_rdata);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic edges(input int n, output int er, output int es);
        int r0, s0;
        r0 = n_ref; s0 = n_ser;
        wait_cyc(n);
        er = n_ref - r0; es = n_ser - s0;
    endtask

    task automatic write_ctrl(input int v);
        logic a, e; int rd;
        xfer(0, 1, v, a, e, rd);
    endtask

    task automatic t_reset();
        logic a, e; int rd, er, es;
        chk("R1 ack idle", int'(bus_ack), 0);
        chk("R1 err idle", int'(bus_err), 0);
        xfer(0, 0, 0, a, e, rd);
        chk("R1 ctrl reads 0", rd, 0);
        edges(50, er, es);
        chk("R1 ref runs", int'(er > 5), 1);
        chk("R1 ser runs", int'(es > 5), 1);
    endtask

    task automatic t_running_access();
        logic a, e; int rd;
        for (int ad = 1; ad < (1 << AW); ad++) begin
            xfer(ad, ad[0], 8'h5a, a, e, rd);
            chk("R6 ack running", int'(a), 1);
            chk("R6 no err running", int'(e), 0);
        end
        xfer(0, 1, 8'hff, a, e, rd);
        chk("R11 ack pulse", int'(a), 1);
        wait_cyc(1);
        chk("R11 ack one cycle", int'(bus_ack), 0);
        xfer(0, 0, 0, a, e, rd);
        chk("R4 mask readback", rd, 3);
        write_ctrl(0);
    endtask

    task automatic t_osc();
        logic a, e; int rd;
        osc_rdy_n = 1; wait_cyc(4);
        xfer(1, 0, 0, a, e, rd);
        chk("R8 osc not ready", rd, 1);
        osc_rdy_n = 0; wait_cyc(4);
        xfer(1, 0, 0, a, e, rd);
        chk("R8 osc ready", rd, 0);
    endtask

    task automatic t_stop();
        logic a, e; int rd, er, es;
        write_ctrl(1);
        wait_cyc(30);
        edges(100, er, es);
        chk("R2 ref stopped", er, 0);
        chk("R2 ser stopped", es, 0);
        chk("R2 ref low", int'(gclk_ref), 0);
        xfer(0, 0, 0, a, e, rd);
        chk("R4 ctrl read stopped", rd, 1);
        chk("R4 ack stopped", int'(a), 1);
        for (int ad = 1; ad < (1 << AW); ad++) begin
            xfer(ad, ad[1], 8'h33, a, e, rd);
            chk("R5 err stopped", int'(e), 1);
            chk("R5 no ack stopped", int'(a), 0);
        end
        wait_cyc(1);
        chk("R11 err one cycle", int'(bus_err), 0);
    endtask

    task automatic t_frozen_cts();
        int er, es;
        cts_en = '1; cts_in = 2'b00; wait_cyc(15);
        write_ctrl(1); wait_cyc(30);
        cts_in = 2'b11; wait_cyc(30);
        chk("R12 cts held while stopped", int'(cts_q), 0);
        write_ctrl(0); wait_cyc(30);
        edges(30, er, es);
        chk("R7 ref restarts", int'(er > 2), 1);
        chk("R7 ser restarts", int'(es > 2), 1);
        chk("R12 cts after restart", int'(cts_q), 3);
    endtask

    task automatic t_cts_select();
        cts_en = '1; cts_in = 2'b00; wait_cyc(15);
        ser_run = 0; wait_cyc(10);
        cts_in = 2'b10; wait_cyc(15);
        write_ctrl(0); wait_cyc(2);
        chk("R9 ref bank", int'(cts_q), 2);
        write_ctrl(2); wait_cyc(2);
        chk("R9 ser bank stale", int'(cts_q), 0);
        ser_run = 1; wait_cyc(20);
        chk("R9 ser bank updated", int'(cts_q), 2);
        write_ctrl(0);
    endtask

    task automatic t_cts_enable();
        cts_en = 2'b11; cts_in = 2'b10; wait_cyc(15);
        cts_en = 2'b01; cts_in = 2'b01; wait_cyc(15);
        chk("R10 ch1 holds ch0 follows", int'(cts_q), 3);
        cts_en = 2'b00; cts_in = 2'b00; wait_cyc(15);
        chk("R10 both hold", int'(cts_q), 3);
        cts_en = 2'b11; wait_cyc(15);
        chk("R10 both follow", int'(cts_q), 0);
    endtask

    task automatic t_hw_reset();
        logic a, e; int rd, er, es;
        write_ctrl(1); wait_cyc(30);
        rst_n = 0; wait_cyc(12); rst_n = 1; wait_cyc(10);
        edges(40, er, es);
        chk("R7 ref after reset", int'(er > 2), 1);
        chk("R7 ser after reset", int'(es > 2), 1);
        xfer(0, 0, 0, a, e, rd);
        chk("R7 ctrl cleared", rd, 0);
    endtask

    initial begin
        rst_n = 0; wait_cyc(12); rst_n = 1; wait_cyc(4);
        mon_on = 1;
        t_reset();
        t_running_access();
        t_osc();
        t_stop();
        write_ctrl(0); wait_cyc(30);
        t_frozen_cts();
        t_cts_select();
        t_cts_enable();
        write_ctrl(1); wait_cyc(20); write_ctrl(0); wait_cyc(20);
        t_hw_reset();
        chk("R3 ref short pulses", short_ref, 0);
        chk("R3 ser short pulses", short_ser, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule